// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block produces the interrupt sources of a synchronous serial port. It looks at how full the transmit and receive FIFOs are and at a few event strobes from the receive path. From these it builds four raw interrupt conditions:

- a transmit watermark;
- a receive watermark;
- a sticky receive timeout;
- a sticky receive overrun.

Software controls a 4-bit enable mask through a simple write strobe, and clears the two sticky sources by writing ones. The block presents the raw vector, the mask, the masked vector, and one combined interrupt line.

The two watermark sources are plain levels taken straight from the FIFO occupancy counts. The timeout source counts bit-period ticks. It counts only while the receive FIFO holds data, the line is idle, and no frame or FIFO read is happening. After 32 such ticks it latches. The overrun source latches when a frame arrives while the receive FIFO is full. It also latches when the receive path reports an overrun directly.

Top module: `sif_irq_ctrl`

## Requirements
- R1: Raw bit 3 (transmit) is 1 whenever `tx_level` is 4 or less, and 0 otherwise. It follows the input in the same cycle and has no enable gating.
- R2: Raw bit 2 (receive) is 1 whenever `rx_level` is 4 or more, and 0 otherwise. It follows the input in the same cycle.
- R3: Raw bit 1 (timeout) becomes 1 in the cycle after the 32nd counted `bit_tick`. A tick is counted only when all of these hold: `rx_level` is non-zero, `port_idle` is high, `rx_frame` is low, and `rx_pop` is low. The count restarts from zero on any cycle with `rx_frame`, `rx_pop`, an empty receive FIFO, or `port_idle` low.
- R4: Once set, the timeout bit clears on the next clock edge in three cases: `rx_level` is zero, `rx_frame` pulses, or a clear write has bit 1 set. After such a clear it stays 0 until a fresh run of 32 counted ticks completes.
- R5: Raw bit 0 (overrun) becomes 1 on the edge after either of two events: `rx_frame` is high while `rx_level` equals the FIFO depth (8), or `rx_ovr` is high. It then holds until a clear write has bit 0 set. FIFO levels have no effect on it.
- R6: A mask write (`mask_wr` high) loads `mask_wdata` into `mask_q` at the next clock edge. At all other times `mask_q` holds its value.
- R7: `masked_q` equals `raw_q` AND `mask_q`, with bit 3 for transmit, bit 2 for receive, bit 1 for timeout and bit 0 for overrun. `irq` is the OR of the four `masked_q` bits.
- R8: A clear write with a 0 in bit 1 or bit 0 leaves the matching sticky bit unchanged. Bits 3 and 2 of `clr_wdata` are ignored.
- R9: If a sticky bit's set condition and its clear write occur in the same cycle, the bit ends up set.
- R10: Synchronous active-low reset sets `mask_q` to 0, clears both sticky bits, and restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | 4 | Transmit FIFO entry count (0..DEPTH) |
| rx_level | input | 4 | Receive FIFO entry count (0..DEPTH) |
| rx_frame | input | 1 | One-cycle strobe: a receive frame completed |
| rx_ovr | input | 1 | One-cycle strobe: the receive path reports an overrun |
| rx_pop | input | 1 | One-cycle strobe: the receive FIFO was read |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| port_idle | input | 1 | High while no frame is being shifted |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | New mask value |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 4 | Write-one-to-clear pattern (bit 1 timeout, bit 0 overrun) |
| mask_q | output | 4 | Current mask |
| raw_q | output | 4 | Raw interrupt vector |
| masked_q | output | 4 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: a FIFO depth of 8 and a 32-tick timeout. With a depth of 8, both sides of each watermark threshold can be driven directly: 4 against 5 entries on transmit, and 3 against 4 on receive. The full count of 8 that triggers an overrun can also be driven. With a 32-tick timeout, the boundary between 31 and 32 ticks, and a restart partway through a run, can be checked within a few hundred cycles.

// File: rtl/sif_irq_pkg.sv
// Package: shared bit positions and fixed thresholds for the serial port
// interrupt controller. Assumes a 4-bit interrupt vector.
package sif_irq_pkg;
    localparam int IRQ_W     = 4;
    localparam int BIT_TX    = 3;
    localparam int BIT_RX    = 2;
    localparam int BIT_TMO   = 1;
    localparam int BIT_OVR   = 0;
    localparam int TX_THRESH = 4;
    localparam int RX_THRESH = 4;

    typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/sif_irq_level.sv
// Module: watermark comparator. Flags whether a FIFO occupancy count is at or
// below (AT_OR_ABOVE=0) or at or above (AT_OR_ABOVE=1) a fixed threshold.
// Purely combinational. Assumes the count never exceeds 2**LW-1.
module sif_irq_level #(
    parameter int LW          = 4,
    parameter int THRESH      = 4,
    parameter bit AT_OR_ABOVE = 1'b0
) (
    input  logic [LW-1:0] level,
    output logic          hit
);
    localparam logic [LW-1:0] THR = LW'(THRESH);

    generate
        if (AT_OR_ABOVE) begin : g_above
            // Compare for the receive-style threshold
            always_comb hit = (level >= THR);
        end else begin : g_below
            // Compare for the transmit-style threshold
            always_comb hit = (level <= THR);
        end
    endgenerate
endmodule

// File: rtl/sif_irq_timeout.sv
// Module: receive timeout source. Counts bit-period ticks while the receive
// FIFO holds data and the line is idle. After TICKS such ticks it latches a
// flag. Received frames, FIFO reads, an empty FIFO and a busy line restart the
// count. Assumes the strobes last one cycle.
module sif_irq_timeout #(
    parameter int TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_empty,
    input  logic rx_frame,
    input  logic rx_pop,
    input  logic port_idle,
    input  logic bit_tick,
    input  logic clr,
    output logic flag
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);
    localparam logic [TW-1:0] FULL = TW'(TICKS);

    logic [TW-1:0] cnt;
    logic          restart;
    logic          fire;

    // Restart and fire conditions for the tick counter
    always_comb begin
        restart = rx_frame | rx_pop | rx_empty | ~port_idle;
        fire    = ~restart & bit_tick & (cnt == LAST);
    end

    // Saturating count of qualified idle ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (bit_tick && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    // Sticky timeout flag; setting wins over every clear cause
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
        else if (rx_empty || rx_frame || clr)
            flag <= 1'b0;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL); // R3
    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> !$past(rx_empty)); // R3
    AST_TMO_CLR_FRAME: assert property (@(posedge clk) disable iff (!rst_n) rx_frame |=> !flag); // R4
    AST_TMO_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) rx_empty |=> !flag); // R4
endmodule

// File: rtl/sif_irq_sticky.sv
// Module: write-one-to-clear sticky flag. A set pulse latches the flag and a
// clear pulse drops it; setting wins when both arrive in one cycle.
module sif_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the event until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr) |=> flag); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set |=> flag); // R9
endmodule

// File: rtl/sif_irq_ctrl.sv
// Module: serial port interrupt controller top. Combines two watermark levels,
// a receive timeout and a receive overrun into raw, masked and combined
// interrupt outputs, and holds the enable mask. Assumes the level inputs lie
// in 0..DEPTH and the strobes last one cycle.
module sif_irq_ctrl
    import sif_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TICKS = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic          rx_frame,
    input  logic          rx_ovr,
    input  logic          rx_pop,
    input  logic          bit_tick,
    input  logic          port_idle,
    input  logic          mask_wr,
    input  logic [3:0]    mask_wdata,
    input  logic          clr_wr,
    input  logic [3:0]    clr_wdata,
    output logic [3:0]    mask_q,
    output logic [3:0]    raw_q,
    output logic [3:0]    masked_q,
    output logic          irq
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic tx_hit, rx_hit, tmo_flag, ovr_flag;
    logic rx_empty, ovr_set;

    // Receive-side conditions shared by the sticky sources
    always_comb begin
        rx_empty = (rx_level == '0);
        ovr_set  = rx_ovr | (rx_frame & (rx_level == FULL_LVL));
    end

    sif_irq_level #(.LW(LW), .THRESH(TX_THRESH), .AT_OR_ABOVE(1'b0)) u_tx_lvl (
        .level (tx_level),
        .hit   (tx_hit)
    );

    sif_irq_level #(.LW(LW), .THRESH(RX_THRESH), .AT_OR_ABOVE(1'b1)) u_rx_lvl (
        .level (rx_level),
        .hit   (rx_hit)
    );

    sif_irq_timeout #(.TICKS(TICKS)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_empty  (rx_empty),
        .rx_frame  (rx_frame),
        .rx_pop    (rx_pop),
        .port_idle (port_idle),
        .bit_tick  (bit_tick),
        .clr       (clr_wr & clr_wdata[BIT_TMO]),
        .flag      (tmo_flag)
    );

    sif_irq_sticky u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovr_set),
        .clr   (clr_wr & clr_wdata[BIT_OVR]),
        .flag  (ovr_flag)
    );

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    // Assemble raw, masked and combined outputs
    always_comb begin
        raw_q          = '0;
        raw_q[BIT_TX]  = tx_hit;
        raw_q[BIT_RX]  = rx_hit;
        raw_q[BIT_TMO] = tmo_flag;
        raw_q[BIT_OVR] = ovr_flag;
        masked_q       = raw_q & mask_q;
        irq            = |masked_q;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) mask_wr |=> mask_q == $past(mask_wdata)); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mask_wr |=> $stable(mask_q)); // R6
    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rx_frame && rx_level == FULL_LVL) |=> raw_q[BIT_OVR]); // R5
    AST_OVR_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n) (raw_q[BIT_OVR] && !(clr_wr && clr_wdata[BIT_OVR])) |=> raw_q[BIT_OVR]); // R8
    AST_MASKED_SUB: assert property (@(posedge clk) disable iff (!rst_n) (masked_q & ~mask_q) == 4'b0000); // R7
endmodule

// File: tb/tb_sif_irq_ctrl.sv
module tb_sif_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_level = 4'd8, rx_level = 4'd0;
    logic       rx_frame = 0, rx_ovr = 0, rx_pop = 0, bit_tick = 0, port_idle = 0;
    logic       mask_wr = 0, clr_wr = 0;
    logic [3:0] mask_wdata = 0, clr_wdata = 0;
    logic [3:0] mask_q, raw_q, masked_q;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sif_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_frame(rx_frame), .rx_ovr(rx_ovr), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .port_idle(port_idle), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata), .mask_q(mask_q), .raw_q(raw_q),
        .masked_q(masked_q), .irq(irq)
    );

    // Vectors: {tx_level, rx_level, mask, expected masked, expected irq in bit 0}
    localparam logic [19:0] VEC [8] = '{
        {4'd0, 4'd0, 4'hF, 4'b1000, 4'd1},
        {4'd4, 4'd3, 4'hF, 4'b1000, 4'd1},
        {4'd5, 4'd4, 4'hF, 4'b0100, 4'd1},
        {4'd8, 4'd8, 4'h8, 4'b0000, 4'd0},
        {4'd3, 4'd7, 4'h4, 4'b0100, 4'd1},
        {4'd6, 4'd2, 4'hF, 4'b0000, 4'd0},
        {4'd4, 4'd4, 4'h0, 4'b0000, 4'd0},
        {4'd1, 4'd5, 4'h8, 4'b1000, 4'd1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            step();
        end
    endtask

    task automatic pulse_clr(input logic [3:0] v);
        clr_wr = 1'b1; clr_wdata = v;
        step();
        clr_wr = 1'b0; clr_wdata = 4'd0;
    endtask

    task automatic pulse_frame();
        rx_frame = 1'b1;
        step();
        rx_frame = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 mask after reset", {4'd0, mask_q}, 8'h00);
        chk("R10 raw after reset", {4'd0, raw_q}, 8'h00);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);

        // R1 R2 R6 R7: vector table
        for (int v = 0; v < 8; v++) begin
            tx_level = VEC[v][19:16];
            rx_level = VEC[v][15:12];
            mask_wr = 1'b1; mask_wdata = VEC[v][11:8];
            step();
            mask_wr = 1'b0;
            step();
            chk("R6 mask load", {4'd0, mask_q}, {4'd0, VEC[v][11:8]});
            chk("R1 tx raw", {7'd0, raw_q[3]}, {7'd0, (VEC[v][19:16] <= 4'd4)});
            chk("R2 rx raw", {7'd0, raw_q[2]}, {7'd0, (VEC[v][15:12] >= 4'd4)});
            chk("R7 masked", {4'd0, masked_q}, {4'd0, VEC[v][7:4]});
            chk("R7 irq", {7'd0, irq}, {7'd0, VEC[v][0]});
        end

        // R3: timeout threshold
        mask_wr = 1'b1; mask_wdata = 4'hF; step(); mask_wr = 1'b0;
        tx_level = 4'd6; rx_level = 4'd2; port_idle = 1'b1;
        step();
        ticks(31);
        chk("R3 no timeout at 31 ticks", {7'd0, raw_q[1]}, 8'd0);
        ticks(1);
        chk("R3 timeout at 32 ticks", {7'd0, raw_q[1]}, 8'd1);
        chk("R7 irq from timeout", {3'd0, irq, masked_q}, {3'd0, 1'b1, 4'b0010});

        // R4 R8: zero write keeps, one write clears, stays clear
        pulse_clr(4'b1101);
        step();
        chk("R8 zero in bit1 keeps timeout", {7'd0, raw_q[1]}, 8'd1);
        pulse_clr(4'b0010);
        step();
        chk("R4 clear write drops timeout", {7'd0, raw_q[1]}, 8'd0);
        ticks(40);
        chk("R4 no re-set after clear", {7'd0, raw_q[1]}, 8'd0);

        // R3: pop restarts the count
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
        ticks(20);
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
        ticks(31);
        chk("R3 pop restarts count", {7'd0, raw_q[1]}, 8'd0);
        ticks(1);
        chk("R3 timeout after restart", {7'd0, raw_q[1]}, 8'd1);

        // R4: empty FIFO clears
        rx_level = 4'd0; step();
        chk("R4 empty clears timeout", {7'd0, raw_q[1]}, 8'd0);

        // R3: idle low restarts; R4: frame clears
        rx_level = 4'd3;
        ticks(10);
        port_idle = 1'b0; step(); port_idle = 1'b1;
        ticks(31);
        chk("R3 busy line restarts count", {7'd0, raw_q[1]}, 8'd0);
        ticks(1);
        chk("R3 timeout after busy", {7'd0, raw_q[1]}, 8'd1);
        pulse_frame(); step();
        chk("R4 frame clears timeout", {7'd0, raw_q[1]}, 8'd0);

        // R5: overrun on full FIFO frame
        rx_level = 4'd7; pulse_frame(); step();
        chk("R5 no overrun below full", {7'd0, raw_q[0]}, 8'd0);
        rx_level = 4'd8; pulse_frame(); step();
        chk("R5 overrun on full frame", {7'd0, raw_q[0]}, 8'd1);
        rx_level = 4'd0; step(); step();
        chk("R5 overrun held after drain", {7'd0, raw_q[0]}, 8'd1);
        pulse_clr(4'b1110); step();
        chk("R8 zero in bit0 keeps overrun", {7'd0, raw_q[0]}, 8'd1);
        pulse_clr(4'b0001); step();
        chk("R5 clear write drops overrun", {7'd0, raw_q[0]}, 8'd0);

        // R9: set and clear together
        rx_level = 4'd8;
        rx_frame = 1'b1; clr_wr = 1'b1; clr_wdata = 4'b0001;
        step();
        rx_frame = 1'b0; clr_wr = 1'b0; clr_wdata = 4'd0;
        step();
        chk("R9 set wins over clear", {7'd0, raw_q[0]}, 8'd1);
        pulse_clr(4'b0001); step();

        // R5: direct overrun strobe
        rx_level = 4'd2;
        rx_ovr = 1'b1; step(); rx_ovr = 1'b0; step();
        chk("R5 strobe sets overrun", {7'd0, raw_q[0]}, 8'd1);

        // R10: reset mid-run
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        chk("R10 mask cleared by reset", {4'd0, mask_q}, 8'h00);
        chk("R10 overrun cleared by reset", {7'd0, raw_q[0]}, 8'd0);
        chk("R10 irq low after reset", {7'd0, irq}, 8'd0);

        finish_run();
    end
endmodule